// File: doc/BRIEF.md
# Sticky Wide Right Shifter

This block shifts a 128-bit quantity, supplied as a high word and a low word of 64 bits each, to the right by an unsigned 16-bit count. It is purely combinational. It serves as the alignment stage in front of a rounding unit. That unit is not part of this block.

The block has two modes, chosen by one select input. In the split-fraction mode the value is treated as fixed point, with the binary point between the two words. The block shifts it right by the count. The integer part comes out on the high output. The low output is an extra word: its most significant bit is the last bit that dropped below the integer part, and its remaining bits are nonzero exactly when any earlier dropped bit was one. In the jamming mode the whole 128-bit value is shifted right by the count. If any discarded bit was one, the result LSB is forced to one. Every count up to the 16-bit maximum follows the large-count rules, with no wrap-around.

Top module: `wide_sticky_shr`

## Requirements
- R1: With a count of zero, `hi_out` equals `hi_in` and `lo_out` equals `lo_in`, in either mode.
- R2: With `jam_mode` = 0 (split-fraction mode) and a count c from 1 to 63, `hi_out` is `hi_in >> c`. `lo_out` is `hi_in << (64 - c)`, with bit 0 additionally ORed with the OR-reduction of `lo_in`.
- R3: With `jam_mode` = 0 and a count of exactly 64, `hi_out` is zero and `lo_out` is `hi_in` with bit 0 ORed with the OR-reduction of `lo_in`.
- R4: With `jam_mode` = 0 and a count from 65 to 255, `hi_out` is zero. `lo_out` is 1 if either input word is nonzero and 0 otherwise.
- R5: With `jam_mode` = 1 (jamming mode) and a count c from 1 to 127, {`hi_out`,`lo_out`} is {`hi_in`,`lo_in`} >> c. Bit 0 of the result is ORed with the OR-reduction of the c discarded bits. For c of 65 to 127, the low result word is therefore `hi_in >> (c mod 64)` with that sticky bit.
- R6: With `jam_mode` = 1 and a count from 128 to 255, `hi_out` is zero. `lo_out` is 1 if the 128-bit input is nonzero and 0 otherwise.
- R7: Counts of 256 and above, up to 16'hFFFF, give the same result as R4 (split-fraction mode) or R6 (jamming mode). Upper count bits never wrap the shift back into range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hi_in | input | 64 | High (integer) word of the 128-bit operand |
| lo_in | input | 64 | Low (fraction) word of the 128-bit operand |
| shamt | input | 16 | Unsigned right-shift count |
| jam_mode | input | 1 | 0 = split-fraction mode, 1 = jamming mode |
| hi_out | output | 64 | Integer word (split mode) or high result word (jam mode) |
| lo_out | output | 64 | Extra word (split mode) or low result word with sticky LSB (jam mode) |

## Verification
The bench concentrates on the count boundaries where the rules change: 0, 1, 63, 64, 65, 127, 128, 129, 255, 256 and 16'hFFFF. A design that handled 64 like the general small case would lose the low-word sticky bit or leave stale integer bits behind. A design that truncated the count to its low bits would wrap 256 to a zero shift and pass the operand through. The data patterns include a lone one in the bottom bit of the low word and a lone one in the bottom bit of the high word. These catch a sticky reduction that misses the low word in split mode, or drops bits removed by one barrel stage in jam mode. All-zero operands at large counts expose a sticky bit that is forced on regardless of the data.

// File: rtl/wsh_pkg.sv
package wsh_pkg;

   typedef enum logic {
      SHR_SPLIT = 1'b0,
      SHR_JAM   = 1'b1
   } shr_mode_e;

   // width of a count that can express 0 .. span inclusive (span a power of two)
   function automatic int unsigned sat_cnt_bits(input int unsigned span);
      return $clog2(span) + 1;
   endfunction

endpackage

// File: rtl/wsh_count_clamp.sv
module wsh_count_clamp #(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned SAT_W  = 8
) (
   input  logic [CNT_W-1:0] cnt_in,
   output logic [SAT_W-1:0] cnt_sat,
   output logic             cnt_zero,
   output logic             cnt_gt_word
);
   localparam int unsigned SPAN = 2 * WORD_W;
   localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(SPAN);
   localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
   localparam logic [SAT_W-1:0] SPAN_S = SAT_W'(SPAN);

   if (CNT_W < SAT_W) begin : g_bad_cnt
      $error("wsh_count_clamp: CNT_W too narrow to reach the full span");
   end

   always_comb begin
      cnt_zero    = (cnt_in == '0);
      cnt_gt_word = (cnt_in > WORD_C);
      if (cnt_in >= SPAN_C) begin
         cnt_sat = SPAN_S;
      end else begin
         cnt_sat = cnt_in[SAT_W-1:0];
      end
   end
endmodule

// File: rtl/wsh_jam_barrel.sv
module wsh_jam_barrel #(
   parameter int unsigned N     = 128,
   parameter int unsigned AMT_W = 8
) (
   input  logic [N-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   output logic [N-1:0]     dout,
   output logic             lost_any
);
   logic [N-1:0] stage_v [AMT_W+1];
   logic         stage_s [AMT_W+1];

   assign stage_v[0] = din;
   assign stage_s[0] = 1'b0;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int unsigned STEP = 1 << k;
      if (STEP >= N) begin : g_full
         assign stage_v[k+1] = amt[k] ? '0 : stage_v[k];
         assign stage_s[k+1] = stage_s[k] | (amt[k] & (|stage_v[k]));
      end else begin : g_part
         assign stage_v[k+1] = amt[k] ? (stage_v[k] >> STEP) : stage_v[k];
         assign stage_s[k+1] = stage_s[k] | (amt[k] & (|stage_v[k][STEP-1:0]));
      end
   end

   assign dout     = stage_v[AMT_W];
   assign lost_any = stage_s[AMT_W];
endmodule

// File: rtl/wsh_result_form.sv
module wsh_result_form
   import wsh_pkg::*;
#(
   parameter int unsigned WORD_W = 64
) (
   input  shr_mode_e           mode,
   input  logic                cnt_zero,
   input  logic                cnt_gt_word,
   input  logic [WORD_W-1:0]   hi_in,
   input  logic [WORD_W-1:0]   lo_in,
   input  logic [2*WORD_W-1:0] shifted,
   input  logic                lost_any,
   output logic [WORD_W-1:0]   hi_out,
   output logic [WORD_W-1:0]   lo_out
);
   logic lo_nz;
   logic op_nz;

   assign lo_nz = |lo_in;
   assign op_nz = lo_nz | (|hi_in);

   always_comb begin
      hi_out = shifted[2*WORD_W-1:WORD_W];
      lo_out = shifted[WORD_W-1:0];
      if (mode == SHR_JAM) begin
         lo_out[0] = shifted[0] | lost_any;
      end else if (cnt_gt_word) begin
         hi_out = '0;
         lo_out = {{(WORD_W-1){1'b0}}, op_nz};
      end else begin
         lo_out[0] = shifted[0] | (lo_nz & ~cnt_zero);
      end
   end
endmodule

// File: rtl/wide_sticky_shr.sv
module wide_sticky_shr
   import wsh_pkg::*;
#(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned CNT_W  = 16
) (
   input  logic [WORD_W-1:0] hi_in,
   input  logic [WORD_W-1:0] lo_in,
   input  logic [CNT_W-1:0]  shamt,
   input  logic              jam_mode,
   output logic [WORD_W-1:0] hi_out,
   output logic [WORD_W-1:0] lo_out
);
   localparam int unsigned SPAN  = 2 * WORD_W;
   localparam int unsigned SAT_W = sat_cnt_bits(SPAN);

   if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("wide_sticky_shr: WORD_W must be a power of two of at least 2");
   end

   shr_mode_e         mode;
   logic [SAT_W-1:0]  cnt_sat;
   logic              cnt_zero;
   logic              cnt_gt_word;
   logic [SPAN-1:0]   bar_in;
   logic [SPAN-1:0]   bar_out;
   logic              bar_lost;

   assign mode = shr_mode_e'(jam_mode);

   // split mode discards the low word's own bits; only its OR survives
   assign bar_in = {hi_in, ((mode == SHR_JAM) || cnt_zero) ? lo_in : {WORD_W{1'b0}}};

   wsh_count_clamp #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W),
      .SAT_W  (SAT_W)
   ) i_clamp (
      .cnt_in      (shamt),
      .cnt_sat     (cnt_sat),
      .cnt_zero    (cnt_zero),
      .cnt_gt_word (cnt_gt_word)
   );

   wsh_jam_barrel #(
      .N     (SPAN),
      .AMT_W (SAT_W)
   ) i_barrel (
      .din      (bar_in),
      .amt      (cnt_sat),
      .dout     (bar_out),
      .lost_any (bar_lost)
   );

   wsh_result_form #(
      .WORD_W (WORD_W)
   ) i_form (
      .mode        (mode),
      .cnt_zero    (cnt_zero),
      .cnt_gt_word (cnt_gt_word),
      .hi_in       (hi_in),
      .lo_in       (lo_in),
      .shifted     (bar_out),
      .lost_any    (bar_lost),
      .hi_out      (hi_out),
      .lo_out      (lo_out)
   );
endmodule

// File: rtl/wide_sticky_shr_chk.sv
module wide_sticky_shr_chk #(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned CNT_W  = 16
) (
   input logic [WORD_W-1:0] hi_in,
   input logic [WORD_W-1:0] lo_in,
   input logic [CNT_W-1:0]  shamt,
   input logic              jam_mode,
   input logic [WORD_W-1:0] hi_out,
   input logic [WORD_W-1:0] lo_out
);
   localparam logic [CNT_W-1:0] C_WORD = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] C_SPAN = CNT_W'(2 * WORD_W);

   logic op_nz;
   logic res_nz;
   assign op_nz  = (|hi_in) | (|lo_in);
   assign res_nz = (|hi_out) | (|lo_out);

   always_comb begin
      if (shamt == '0) begin
         p_pass_r1: assert (hi_out == hi_in && lo_out == lo_in);
      end
      if (!jam_mode && shamt != '0 && shamt < C_WORD) begin
         p_split_keeps_r2: assert (res_nz == op_nz);
      end
      if (!jam_mode && shamt == C_WORD) begin
         p_int_clear_r3: assert (hi_out == '0);
      end
      if (!jam_mode && shamt > C_WORD) begin
         p_flag_only_r4: assert (hi_out == '0 && lo_out[WORD_W-1:1] == '0 && lo_out[0] == op_nz);
      end
      if (jam_mode && shamt < C_SPAN) begin
         p_jam_keeps_r5: assert (res_nz == op_nz);
      end
      if (jam_mode && shamt >= C_SPAN) begin
         p_jam_flag_r6: assert (hi_out == '0 && lo_out[WORD_W-1:1] == '0 && lo_out[0] == op_nz);
      end
   end
endmodule

bind wide_sticky_shr wide_sticky_shr_chk #(
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) i_chk (
   .hi_in    (hi_in),
   .lo_in    (lo_in),
   .shamt    (shamt),
   .jam_mode (jam_mode),
   .hi_out   (hi_out),
   .lo_out   (lo_out)
);

// File: tb/test_wide_sticky_shr.sv
module test_wide_sticky_shr;
   localparam int W = 64;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0]  hi_in = '0, lo_in = '0;
   logic [CW-1:0] shamt = '0;
   logic          jam_mode = 1'b0;
   logic [W-1:0]  hi_out, lo_out;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   wide_sticky_shr #(.WORD_W(W), .CNT_W(CW)) i_wide_sticky_shr (
      .hi_in(hi_in), .lo_in(lo_in), .shamt(shamt), .jam_mode(jam_mode),
      .hi_out(hi_out), .lo_out(lo_out));

   // behavioural expectation taken from the requirement text
   function automatic logic [127:0] expect_val(input logic [63:0] h, input logic [63:0] l,
                                               input int unsigned c, input logic jam);
      logic [127:0] v, r, lost, t;
      v = {h, l};
      if (c == 0) return v;
      if (jam) begin
         if (c >= 128) return {127'b0, (v != 0)};
         r = v >> c;
         lost = v & ((128'd1 << c) - 128'd1);
         if (lost != 0) r[0] = 1'b1;
         return r;
      end
      if (c > 64) return {127'b0, (v != 0)};
      t = {h, 64'b0} >> c;
      if (l != 0) t[0] = 1'b1;
      return t;
   endfunction

   function automatic string req_of(input int unsigned c, input logic jam);
      if (c == 0) return "R1";
      if (c >= 256) return "R7";
      if (!jam) begin
         if (c < 64) return "R2";
         if (c == 64) return "R3";
         return "R4";
      end
      if (c < 128) return "R5";
      return "R6";
   endfunction

   task automatic apply_and_check(input logic [63:0] h, input logic [63:0] l,
                                  input int unsigned c, input logic jam);
      logic [127:0] exp_v;
      @(posedge clk);
      #1;
      hi_in = h; lo_in = l; shamt = CW'(c); jam_mode = jam;
      @(negedge clk);
      exp_v = expect_val(h, l, c, jam);
      n_checks++;
      if ({hi_out, lo_out} !== exp_v) begin
         n_errors++;
         $display("FAIL %s cnt=%0d jam=%0b in=%h_%h got=%h_%h exp=%h_%h",
                  req_of(c, jam), c, jam, h, l, hi_out, lo_out,
                  exp_v[127:64], exp_v[63:0]);
      end
   endtask

   function automatic logic [127:0] pattern(input int idx);
      case (idx)
         0: return 128'd0;
         1: return {128{1'b1}};
         2: return {64'd1, 64'd0};
         3: return {64'd0, 64'd1};
         4: return {64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000};
         default: return {$urandom, $urandom, $urandom, $urandom};
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      int unsigned edge_cnts [14];
      logic [127:0] p;
      edge_cnts = '{0, 1, 2, 31, 63, 64, 65, 100, 127, 128, 129, 255, 256, 65535};
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: zero operand, zero count -> zero result (R1)
      @(negedge clk);
      n_checks++;
      if (hi_out !== '0 || lo_out !== '0) begin
         n_errors++;
         $display("FAIL R1 idle got=%h_%h exp=0_0", hi_out, lo_out);
      end
      for (int m = 0; m < 2; m++) begin
         for (int pi = 0; pi < 6; pi++) begin
            for (int ci = 0; ci < 14; ci++) begin
               p = pattern(pi);
               apply_and_check(p[127:64], p[63:0], edge_cnts[ci], m[0]);
            end
         end
      end
      // random sweep; mostly in-range counts, some over the full 16-bit range (R7)
      for (int i = 0; i < 600; i++) begin
         int unsigned c;
         p = pattern(5);
         if (i % 4 == 0) p[63:0] = '0;
         if (i % 7 == 0) p[127:64] = 64'd1 << $urandom_range(0, 63);
         c = (i % 5 == 0) ? $urandom_range(0, 65535) : $urandom_range(0, 140);
         apply_and_check(p[127:64], p[63:0], c, $urandom_range(0, 1) == 1);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule